// File: doc/BRIEF.md
# Multiplier Built-In Self-Test Engine

This block wraps a small combinational multiplier with everything it needs to test itself. When `start` is pulsed, a controller loads a 4-bit maximal-length LFSR with a fixed seed and clears a 4-bit signature register. It then steps through all fifteen nonzero LFSR states, one per clock. Each state is cut into two 2-bit operands that drive a carry-save array multiplier. Every 4-bit product is folded into the signature register, with each product bit feeding its own stage.

After the last vector, the controller compares the signature once with a reference constant. That constant is a parameter, learned from a fault-free run. `done` then rises and stays high, together with the verdict on `pass`, until the next `start`. A debug input inverts one chosen product bit for as long as it is held. This lets a fault be planted in a single vector or across the whole run.

The block has no streaming data path. Every pin is a plain control or status level, so no valid/ready handshake and no back-pressure apply.

Top module: `bist_mult_selftest`

## Requirements
- R1: While reset is applied and on the first cycle after its release, `done` and `pass` are both 0.
- R2: A `start` sampled high while the block is idle or finished begins a run. `done` becomes 1 after exactly 16 further rising edges: 15 vectors plus one compare cycle.
- R3: The pattern register loads 4'b0001 at start. Its next value is `{q[2:0], q[3]^q[2]}` (polynomial 1 + x^3 + x^4), and it visits 15 distinct nonzero states per run.
- R4: Operand A is pattern bits [3:2] and operand B is bits [1:0]. The array multiplier returns the unsigned 4-bit product A*B.
- R5: The signature register clears at start. On each vector it becomes `{s[2:0], s[3]^s[2]} ^ d`, where d is the 4-bit response.
- R6: On a fault-free run the signature equals the parameter `GOLDEN` (default 4'b0100), and `pass` reads 1 while `done` is high.
- R7: While `fault_en` is 1, response bit `fault_pos` (0 = LSB) is inverted. Inverting it for a single vector makes `pass` read 0.
- R8: `start` has no effect while a run or compare is in progress. `done` still rises on the schedule of the first start.
- R9: `done` and the verdict hold until a new `start` is sampled. One edge later, `done` and `pass` are 0.
- R10: Inverting the same response bit on all 15 vectors cancels out in the signature, so `pass` reads 1.
- R11: `pass` is 0 in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a self-test run (idle or finished state only) |
| fault_en | input | 1 | Debug: invert one response bit this cycle |
| fault_pos | input | 2 | Index of the response bit to invert |
| done | output | 1 | Run complete, verdict valid |
| pass | output | 1 | 1 = signature matched reference |

## Verification
The hardest case to reach from the ports is a corrupted response that still produces the golden signature. To get there, `fault_en` is held across the full fifteen-vector window. This shows that a constant error pattern cycles through the whole register period and cancels out. It is set against one-cycle injections at each bit position, which must all end in a fail. The bench also pulses `start` in the middle of a run to show that the schedule of the first launch is kept.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CMP  = 2'd2,
    ST_DONE = 2'd3
  } bst_state_e;
endpackage

// File: rtl/bst_pattern_lfsr.sv
module bst_pattern_lfsr #(
  parameter int             W        = 4,
  parameter logic [W-1:0]   TAP_MASK = 4'b1100,
  parameter logic [W-1:0]   SEED     = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] pat
);
  logic [W-1:0] q;
  logic         fb;

  assign fb  = ^(q & TAP_MASK);
  assign pat = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SEED;
    else if (load) q <= SEED;
    else if (step) q <= {q[W-2:0], fb};
  end

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);

  // R3
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> q != $past(q));
endmodule

// File: rtl/bst_array_mult.sv
module bst_array_mult #(
  parameter int N = 2
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  logic [N-1:0][N-1:0] pp;
  logic [N-1:0][N-1:0] rs;
  logic [N-1:0][N:0]   rc;

  for (genvar i = 0; i < N; i++) begin : g_pp
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign pp[i][j] = a[j] & b[i];
    end
  end

  assign rs[0] = pp[0];
  assign rc[0] = '0;

  for (genvar i = 1; i < N; i++) begin : g_row
    logic [N-1:0] x;
    assign x = {rc[i-1][N], rs[i-1][N-1:1]};
    assign rc[i][0] = 1'b0;
    for (genvar j = 0; j < N; j++) begin : g_fa
      assign rs[i][j]   = x[j] ^ pp[i][j] ^ rc[i][j];
      assign rc[i][j+1] = (x[j] & pp[i][j]) | (rc[i][j] & (x[j] ^ pp[i][j]));
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_low
    assign p[i] = rs[i][0];
  end
  assign p[2*N-1:N] = {rc[N-1][N], rs[N-1][N-1:1]};

  // R4
  always_comb begin
    mult_product_chk: assert (p == (2*N)'(a) * (2*N)'(b));
  end
endmodule

// File: rtl/bst_sig_reg.sv
module bst_sig_reg #(
  parameter int           W        = 4,
  parameter logic [W-1:0] TAP_MASK = 4'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         absorb,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig
);
  logic [W-1:0] s;
  logic         fb;

  assign fb  = ^(s & TAP_MASK);
  assign sig = s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      s <= '0;
    else if (clear)  s <= '0;
    else if (absorb) s <= {s[W-2:0], fb} ^ resp;
  end

  // R5
  sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !absorb) |=> $stable(s));
endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl
  import bst_pkg::*;
#(
  parameter int NUM_VEC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sig_match,
  output logic clr,
  output logic run,
  output logic done,
  output logic pass
);
  localparam int            CW   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_VEC - 1);

  bst_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          pass_q;
  logic          can_start;

  assign can_start = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign clr       = start && can_start;
  assign run       = (st_q == ST_RUN);
  assign done      = (st_q == ST_DONE);
  assign pass      = pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            st_q   <= ST_RUN;
            cnt_q  <= '0;
            pass_q <= 1'b0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_CMP;
        end
        ST_CMP: begin
          pass_q <= sig_match;
          st_q   <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  pass_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pass);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && !pass));

  // R8
  run_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != LAST) |=> run);

  // R2
  run_to_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == LAST) |=> (st_q == ST_CMP));

  // R2
  cmp_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMP) |=> done);
endmodule

// File: rtl/bist_mult_selftest.sv
module bist_mult_selftest #(
  parameter int                 OPW      = 2,
  parameter logic [2*OPW-1:0]   TAP_MASK = 4'b1100,
  parameter logic [2*OPW-1:0]   SEED     = 4'b0001,
  parameter logic [2*OPW-1:0]   GOLDEN   = 4'b0100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        fault_en,
  input  logic [$clog2(2*OPW)-1:0]    fault_pos,
  output logic                        done,
  output logic                        pass
);
  localparam int PW      = 2 * OPW;
  localparam int NUM_VEC = (1 << PW) - 1;

  logic          clr, run;
  logic [PW-1:0] pat, prod, resp, sig, flip;

  bst_ctrl #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sig_match(sig == GOLDEN),
    .clr      (clr),
    .run      (run),
    .done     (done),
    .pass     (pass)
  );

  bst_pattern_lfsr #(.W(PW), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_pat (
    .clk  (clk),
    .rst_n(rst_n),
    .load (clr),
    .step (run),
    .pat  (pat)
  );

  bst_array_mult #(.N(OPW)) u_cut (
    .a(pat[PW-1:OPW]),
    .b(pat[OPW-1:0]),
    .p(prod)
  );

  assign flip = fault_en ? (PW'(1) << fault_pos) : '0;
  assign resp = prod ^ flip;

  bst_sig_reg #(.W(PW), .TAP_MASK(TAP_MASK)) u_sig (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr),
    .absorb(run),
    .resp  (resp),
    .sig   (sig)
  );

  // R6
  verdict_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(sig) == GOLDEN);

  // R7
  fault_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_en |-> $countones(resp ^ prod) == 1);
endmodule

// File: tb/sim_bist_mult_selftest.sv
`timescale 1ns/1ps
module sim_bist_mult_selftest;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       fault_en = 1'b0;
  logic [1:0] fault_pos = 2'd0;
  logic       done, pass;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bist_mult_selftest u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fault_en(fault_en), .fault_pos(fault_pos),
    .done(done), .pass(pass)
  );

  // Behavioural reference: phase 0 idle, 1 run, 2 compare, 3 finished
  int m_phase = 0, m_idx = 0, m_pat = 1, m_sig = 0, m_pass = 0;
  int m_trace[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_pass <= 0;
    end else begin
      case (m_phase)
        0, 3: if (start) begin
          m_phase <= 1; m_idx <= 0; m_pat <= 1; m_sig <= 0; m_pass <= 0;
          m_trace.delete();
        end
        1: begin
          int a, b, d, nxt;
          a = m_pat / 4;
          b = m_pat % 4;
          d = (a * b) % 16;
          if (fault_en) d = d ^ (1 << fault_pos);
          nxt = ((m_sig * 2) % 16) + (((m_sig / 8) + (m_sig / 4)) % 2);
          m_sig <= nxt ^ d;
          m_trace.push_back(m_pat);
          m_pat <= ((m_pat * 2) % 16) + (((m_pat / 8) + (m_pat / 4)) % 2);
          m_idx <= m_idx + 1;
          if (m_idx == 14) m_phase <= 2;
        end
        2: begin
          m_pass <= (m_sig == 4) ? 1 : 0;
          m_phase <= 3;
        end
        default: m_phase <= 0;
      endcase
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (done !== (m_phase == 3)) begin
        n_fail++;
        $display("FAIL R2 done per-cycle: actual %0b expected %0b", done, (m_phase == 3));
      end
      n_chk++;
      if (pass !== ((m_phase == 3) && m_pass == 1)) begin
        n_fail++;
        $display("FAIL R11 pass per-cycle: actual %0b expected %0b", pass, (m_phase == 3) && m_pass == 1);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Launch a run; flt_vec selects one vector to corrupt (-1 none, 99 all)
  task automatic do_run(input int flt_vec, input int pos, input int mid_start, output int lat);
    lat = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k < 40; k++) begin
      if (done && lat < 0) lat = k - 1;
      if (lat >= 0) begin
        fault_en = 1'b0;
        break;
      end
      fault_en  = (flt_vec == 99 && k <= 15) || (flt_vec == k - 1);
      fault_pos = 2'(pos);
      start     = (k == mid_start);
      @(negedge clk);
    end
    fault_en = 1'b0;
    start    = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done, 0);
    chk("R1 pass in reset", pass, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 pass after reset", pass, 0);

    // Fault-free run
    do_run(-1, 0, -1, lat);
    chk("R2 latency", lat, 16);
    chk("R6 fault-free pass", pass, 1);
    chk("R5 model signature", m_sig, 4);
    chk("R3 distinct patterns", m_trace.size(), 15);
    begin
      int seen = 0;
      foreach (m_trace[i]) seen = seen | (1 << m_trace[i]);
      chk("R3 all nonzero states", seen, 16'hFFFE);
      chk("R3 seed first", m_trace[0], 1);
      chk("R4 third operand pair", (m_trace[3] / 4) * (m_trace[3] % 4), 2);
    end

    // Hold
    repeat (10) @(negedge clk);
    chk("R9 done held", done, 1);
    chk("R9 pass held", pass, 1);

    // Restart drops done and pass one edge after start
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 done drops", done, 0);
    chk("R11 pass drops", pass, 0);
    repeat (20) @(negedge clk);
    chk("R6 rerun pass", pass, 1);

    // Single-vector faults on each bit
    for (int b = 0; b < 4; b++) begin
      do_run(3 + 3 * b, b, -1, lat);
      chk("R7 single fault latency", lat, 16);
      chk("R7 single fault fails", pass, 0);
    end

    // Fault on a vector with zero product still flips a bit
    do_run(0, 3, -1, lat);
    chk("R7 fault on zero product", pass, 0);

    // Constant inversion over all vectors aliases
    for (int b = 0; b < 4; b++) begin
      do_run(99, b, -1, lat);
      chk("R10 full-run fault aliases", pass, 1);
    end

    // Start mid-run ignored
    do_run(-1, 0, 6, lat);
    chk("R8 latency unchanged", lat, 16);
    chk("R8 verdict unchanged", pass, 1);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule